// File: doc/BRIEF.md
# Single-Gate Bit-Serial Stored-Program Processor

This block evaluates an arbitrary logic circuit one gate per clock using one programmable two-input gate. Every operand and every intermediate result lives in a small bank of one-bit slots. A program counter walks a small instruction store. Each instruction does exactly one of four things:
- copy the external input bit into a slot;
- apply the gate to two slots and store the result;
- copy a slot into the output register;
- do nothing.

Every instruction completes in one clock. A program is written into the instruction store through a simple write port while reset is held. Releasing reset starts execution at address 0. The program then repeats forever, because the counter wraps.

Top module: `bitgate_cpu`

## Requirements
- R1: While `rst` is high, on each clock edge the program counter goes to 0, all data slots go to 0 and `out_bit` goes to 0.
- R2: An instruction word is 15 bits: bits [14:13] kind, bits [12:9] gate truth table, bits [8:6] first source slot, bits [5:3] second source slot, bits [2:0] destination slot.
- R3: Kind 00 writes the current `in_bit` into the destination slot. The gate is bypassed.
- R4: Kind 01 writes the gate result into the destination slot. The result is `table[3 - {s1,s2}]`, where s1 and s2 are the values of the first and second source slots. So table 0001 is AND, 0110 is XOR, 0111 is OR and 1100 is NOT of the first source.
- R5: Kind 10 loads `out_bit` from the first source slot at the clock edge that ends the instruction. Every other kind leaves `out_bit` unchanged.
- R6: Kind 11 changes neither the slots nor `out_bit`. It only advances the program counter.
- R7: Out of reset, the program counter rises by 1 every clock and wraps from 15 to 0, so a 16-word program repeats.
- R8: A slot written by one instruction is read by the next instruction with the new value. An instruction whose source and destination are the same slot reads the old value.
- R9: `prog_we` stores `prog_data` at `prog_addr` only while `rst` is high. A write attempted while running changes no instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also the program-load window |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 4 | Instruction store write address |
| prog_data | input | 15 | Instruction word to store |
| in_bit | input | 1 | External input bit sampled by kind 00 |
| out_bit | output | 1 | Output register |

## Verification
The bench sweeps all sixteen truth tables over every pairing of operand values. A design with the table index reversed would turn AND into NOR, and the mismatch would show on the output. A self-referencing gate (NOT of a slot into that same slot) runs twice in a row; a design that forwarded the result it is writing, or delayed writes by a cycle, would print the wrong alternation. Programs run well past the 16-word boundary to expose a counter that saturates instead of wrapping. Further runs check that a write attempted while running is dropped, that a mid-run reset clears the slots, and that the no-op kind and the input kind never disturb `out_bit`.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
   typedef enum logic [1:0] {
      K_INPUT = 2'b00,
      K_GATE  = 2'b01,
      K_OUT   = 2'b10,
      K_NOP   = 2'b11
   } kind_e;
endpackage

// File: rtl/bgc_imem.sv
module bgc_imem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 15
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/bgc_slots.sv
module bgc_slots #(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] rb,
   output logic          qa,
   output logic          qb
);
   localparam int N = 1 << AW;
   logic [N-1:0] bits;

   for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)                                   bits[g] <= 1'b0;
         else if (we && waddr == AW'(g))            bits[g] <= wbit;
      end
   end

   assign qa = bits[ra];
   assign qb = bits[rb];
endmodule

// File: rtl/bgc_gate.sv
module bgc_gate #(
   parameter int TW        = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [TW-1:0] tbl,
   input  logic          a,
   input  logic          b,
   output logic          y
);
   localparam int IW = $clog2(TW);
   logic [IW-1:0] idx;
   assign idx = {a, b};

   if (MSB_FIRST) begin : g_msb
      assign y = tbl[IW'(TW - 1) - idx];
   end else begin : g_lsb
      assign y = tbl[idx];
   end
endmodule

// File: rtl/bitgate_cpu.sv
module bitgate_cpu #(
   parameter int PC_W    = 4,
   parameter int SLOT_AW = 3,
   parameter int OP_W    = 4,
   parameter int KIND_W  = 2,
   parameter int INSTR_W = KIND_W + OP_W + 3 * SLOT_AW
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               prog_we,
   input  logic [PC_W-1:0]    prog_addr,
   input  logic [INSTR_W-1:0] prog_data,
   input  logic               in_bit,
   output logic               out_bit
);
   import bgc_pkg::*;

   localparam int TBL_LO  = 3 * SLOT_AW;
   localparam int KIND_LO = TBL_LO + OP_W;

   if (OP_W != 4)                             begin : g_bad_op   $error("OP_W must be 4"); end
   if (KIND_W != 2)                           begin : g_bad_kind $error("KIND_W must be 2"); end
   if (SLOT_AW < 1)                           begin : g_bad_slot $error("SLOT_AW must be >= 1"); end
   if (INSTR_W != KIND_W + OP_W + 3*SLOT_AW)  begin : g_bad_iw   $error("INSTR_W mismatch"); end

   logic [PC_W-1:0]    pc;
   logic [INSTR_W-1:0] instr;
   kind_e              kind;
   logic [OP_W-1:0]    tbl;
   logic [SLOT_AW-1:0] src_a, src_b, dst;
   logic               qa, qb, gate_y, wr_en, wr_bit;

   bgc_imem #(.ADDR_W(PC_W), .DATA_W(INSTR_W)) u_imem (
      .clk(clk), .we(prog_we & rst), .waddr(prog_addr), .wdata(prog_data),
      .raddr(pc), .rdata(instr)
   );

   assign kind  = kind_e'(instr[KIND_LO +: KIND_W]);
   assign tbl   = instr[TBL_LO +: OP_W];
   assign src_a = instr[2*SLOT_AW +: SLOT_AW];
   assign src_b = instr[SLOT_AW +: SLOT_AW];
   assign dst   = instr[0 +: SLOT_AW];

   bgc_slots #(.AW(SLOT_AW)) u_slots (
      .clk(clk), .rst(rst), .we(wr_en), .waddr(dst), .wbit(wr_bit),
      .ra(src_a), .rb(src_b), .qa(qa), .qb(qb)
   );

   bgc_gate #(.TW(OP_W), .MSB_FIRST(1'b1)) u_gate (
      .tbl(tbl), .a(qa), .b(qb), .y(gate_y)
   );

   assign wr_en  = (kind == K_INPUT) || (kind == K_GATE);
   assign wr_bit = (kind == K_INPUT) ? in_bit : gate_y;

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                 out_bit <= 1'b0;
      else if (kind == K_OUT)  out_bit <= qa;
   end
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
   parameter int PC_W = 4,
   parameter int OP_W = 4
) (
   input logic            clk,
   input logic            rst,
   input logic [PC_W-1:0] pc,
   input logic [1:0]      kind,
   input logic [OP_W-1:0] tbl,
   input logic            a,
   input logic            b,
   input logic            gate_y,
   input logic            out_bit
);
   a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc == '0 && out_bit == 1'b0));

   a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (rst || pc == PC_W'($past(pc) + 1'b1)));

   a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
      (kind != 2'b10) |=> (rst || $stable(out_bit)));

   a_r5_out_load: assert property (@(posedge clk) disable iff (rst)
      (kind == 2'b10) |=> (rst || out_bit == $past(a)));

   a_r4_and_table: assert property (@(posedge clk) disable iff (rst)
      (kind == 2'b01 && tbl == 4'b0001) |-> (gate_y == (a & b)));

   a_r4_xor_table: assert property (@(posedge clk) disable iff (rst)
      (kind == 2'b01 && tbl == 4'b0110) |-> (gate_y == (a ^ b)));
endmodule

bind bitgate_cpu bgc_checker #(.PC_W(PC_W), .OP_W(OP_W)) u_bgc_checker (
   .clk(clk), .rst(rst), .pc(pc), .kind(instr[KIND_LO +: KIND_W]), .tbl(tbl),
   .a(qa), .b(qb), .gate_y(gate_y), .out_bit(out_bit)
);

// File: tb/test_bitgate_cpu.sv
module test_bitgate_cpu;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        prog_we = 1'b0;
   logic [3:0]  prog_addr = '0;
   logic [14:0] prog_data = '0;
   logic        in_bit = 1'b0;
   logic        out_bit;

   int nchk = 0;
   int nerr = 0;

   logic [14:0] m_prog [16];
   bit [7:0]    m_slot;
   int          m_pc;
   bit          m_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitgate_cpu i_bitgate_cpu (
      .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .in_bit(in_bit), .out_bit(out_bit)
   );

   function automatic logic [14:0] enc(int k, int t, int s1, int s2, int d);
      return {2'(k), 4'(t), 3'(s1), 3'(s2), 3'(d)};
   endfunction

   task automatic check(string tag);
      nchk++;
      if (out_bit !== m_out) begin
         nerr++;
         $display("FAIL %s: out_bit=%0b expected=%0b (t=%0t)", tag, out_bit, m_out, $time);
      end
   endtask

   task automatic model_step(bit ib);
      logic [14:0] w;
      bit a, b, y;
      int idx;
      w   = m_prog[m_pc];
      a   = m_slot[w[8:6]];
      b   = m_slot[w[5:3]];
      idx = 3 - int'({a, b});
      y   = w[9 + idx];
      case (w[14:13])
         2'b00: m_slot[w[2:0]] = ib;
         2'b01: m_slot[w[2:0]] = y;
         2'b10: m_out = a;
         default: ;
      endcase
      m_pc = (m_pc + 1) % 16;
   endtask

   task automatic run(bit ib, string tag);
      in_bit = ib;
      model_step(ib);
      @(negedge clk);
      check(tag);
   endtask

   task automatic enter_reset();
      rst = 1'b1;
      m_slot = '0; m_pc = 0; m_out = 1'b0;
      @(negedge clk);
      check("R1 reset");
   endtask

   task automatic load(int addr, logic [14:0] w);
      prog_we = 1'b1; prog_addr = 4'(addr); prog_data = w;
      m_prog[addr] = w;
      @(negedge clk);
      prog_we = 1'b0;
      check("R9 load in reset");
   endtask

   task automatic fill_nops();
      for (int i = 0; i < 16; i++) load(i, enc(3, 4'hF, 7, 7, 7));
   endtask

   function automatic bit pat(int i);
      logic [31:0] p = 32'hB4E1_96C3;
      return p[i % 32];
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      nerr++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      @(negedge clk);
      enter_reset();

      // Full adder: R2 R3 R4 R5 R6 R7 R8
      fill_nops();
      load(0,  enc(0, 0, 0, 0, 0));        // a -> s0
      load(1,  enc(0, 0, 0, 0, 1));        // b -> s1
      load(2,  enc(0, 0, 0, 0, 2));        // c -> s2
      load(3,  enc(1, 4'b0001, 0, 1, 3));  // AND
      load(4,  enc(1, 4'b0110, 0, 1, 4));  // XOR
      load(5,  enc(1, 4'b0110, 4, 2, 5));  // sum
      load(6,  enc(2, 0, 5, 0, 0));        // out sum
      load(7,  enc(1, 4'b0001, 4, 2, 6));
      load(8,  enc(1, 4'b0111, 3, 6, 7));  // carry
      load(10, enc(2, 0, 7, 0, 0));        // out carry
      load(12, enc(0, 0, 0, 0, 1));        // input kind: out unchanged
      rst = 1'b0;
      for (int i = 0; i < 80; i++) run(pat(i), "R4 R7 adder and wrap");

      // Every truth table over operand pairs (R4)
      for (int t = 0; t < 16; t++) begin
         enter_reset();
         fill_nops();
         load(0, enc(0, 0, 0, 0, 2));
         load(1, enc(0, 0, 0, 0, 5));
         load(2, enc(1, t, 2, 5, 6));
         load(3, enc(2, 0, 6, 0, 0));
         rst = 1'b0;
         for (int i = 0; i < 64; i++) run((i % 16 == 0) ? bit'((i >> 4) & 1) :
                                         (i % 16 == 1) ? bit'((i >> 5) & 1) : pat(i),
                                         "R4 truth table");
      end

      // Same slot as source and destination (R8), NOT table 1100
      enter_reset();
      fill_nops();
      load(0, enc(0, 0, 0, 0, 3));
      load(1, enc(1, 4'b1100, 3, 3, 3));
      load(2, enc(2, 0, 3, 0, 0));
      load(3, enc(1, 4'b1100, 3, 3, 3));
      load(4, enc(2, 0, 3, 0, 0));
      load(5, enc(3, 4'b1111, 3, 3, 3));   // nop with nonzero fields (R6)
      load(6, enc(2, 0, 3, 0, 0));
      rst = 1'b0;
      for (int i = 0; i < 48; i++) run(pat(i + 7), "R8 self-referencing slot");

      // Writes while running are dropped (R9)
      for (int i = 0; i < 16; i++) begin
         prog_we = 1'b1; prog_addr = 4'(i); prog_data = enc(2, 0, 0, 0, 0);
         run(pat(i + 3), "R9 write while running ignored");
      end
      prog_we = 1'b0;
      for (int i = 0; i < 32; i++) run(pat(i + 11), "R9 program unchanged");

      // Mid-run reset clears slots (R1)
      enter_reset();
      fill_nops();
      load(0, enc(2, 0, 3, 0, 0));
      load(1, enc(0, 0, 0, 0, 4));
      load(2, enc(2, 0, 4, 0, 0));
      load(3, enc(2, 0, 3, 0, 0));
      rst = 1'b0;
      for (int i = 0; i < 32; i++) run(pat(i * 3), "R1 slots cleared, R3 input load");

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule